// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block holds the pending-event flags and the per-event enable mask of a general-purpose peripheral interface that sits on an 8-bit register bus. Neighbouring blocks (the serial shift unit and two timers) raise single-cycle set pulses when their events occur. Software acknowledges an event by writing a one to its flag. Neighbours acknowledge one by pulsing a per-source clear strobe when their own data is accessed. A read of the shift data register, which this block decodes itself, clears the shift flag.

The enable register uses a set/clear write convention: data bit 7 decides whether the ones in bits 6..0 turn enables on or off, so software never needs a read-modify-write. Reading the flag register returns a summary bit in position 7 that shows whether any enabled event is pending. A single level interrupt request is raised only for the shift and timer-1 events. Timer 2 is flagged and can be polled, but it never asserts the request.

Top module: `irq_flag_pair`

## Requirements
- R1: After reset every flag and every enable bit is 0: a flag-register read returns 0x00, an enable-register read returns 0x80, and the request is low.
- R2: A set pulse on source bit k (k in 0..6) makes flag k read as 1 from the cycle after the pulse.
- R3: A write to the flag register (index 13) clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. Data bit 7 is ignored.
- R4: A write to the enable register (index 14) with data bit 7 = 1 ORs data bits 6..0 into the enables.
- R5: A write to the enable register with data bit 7 = 0 clears each enable whose data bit is 1.
- R6: A flag-register read returns the flags in bits 6..0. Bit 7 is 1 exactly when some bit 0..6 is set in both the flags and the enables.
- R7: An enable-register read returns the enables in bits 6..0, with bit 7 always 1.
- R8: The request output is high exactly when flags AND enables has bit 2 (shift) or bit 6 (timer 1) set. Bit 5 (timer 2) never drives it.
- R9: A read of the shift data register (index 10) clears flag bit 2 and leaves the other flags unchanged.
- R10: A pulse on clear strobe bit k clears flag k from the next cycle.
- R11: A set pulse and any clear of the same flag in the same cycle leave that flag set.
- R12: The register index is address bits 12..9, and address bits 8..0 are ignored. Writes to other indices change nothing. Read data is 0x00 unless a read of index 13 or 14 is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 13 | Byte address; bits 12..9 select the register |
| wrData | input | 8 | Write data |
| setPulse | input | 7 | Per-source event set pulses (bit 2 shift, 5 timer 2, 6 timer 1) |
| clrAccess | input | 7 | Per-source clear-on-access strobes from neighbours |
| rdData | output | 8 | Read data, combinational from current state |
| irqOut | output | 1 | Level interrupt request |

## Verification
A wrong flag or enable bit in this block becomes visible at the ports within one cycle. It shows as a wrong value on the next flag or enable read, and when the bit belongs to the shift or timer-1 source it shows at once on the request output. The bench runs a behavioural model next to the block and compares the request and the read data on every clock. The stimulus makes each register read follow the cycle it depends on, and it drives set and clear of the same flag in a single cycle so that the lost-event case is observed directly.

// File: rtl/irq_flag_pair_pkg.sv
package irq_flag_pair_pkg;
  localparam int SRC_N = 7;

  typedef struct packed {
    logic             flagWr;
    logic             enWr;
    logic             enSet;
    logic             shiftRd;
    logic             flagRd;
    logic             enRd;
    logic [SRC_N-1:0] bits;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_flag_pair_decode.sv
module irq_flag_pair_decode
  import irq_flag_pair_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int IDX_LO    = 9,
  parameter int IDX_W     = 4,
  parameter int DATA_W    = 8,
  parameter int IDX_FLAG  = 13,
  parameter int IDX_EN    = 14,
  parameter int IDX_SHIFT = 10
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrobes_t      strb
);
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [IDX_W-1:0] regIdx;
  logic unusedAddrLo;

  assign regIdx       = busAddr[IDX_HI:IDX_LO];
  assign unusedAddrLo = ^busAddr[IDX_LO-1:0];

  always_comb begin
    strb         = '0;
    strb.bits    = wrData[SRC_N-1:0];
    strb.enSet   = wrData[DATA_W-1];
    strb.flagWr  = busWr && (regIdx == IDX_W'(IDX_FLAG));
    strb.enWr    = busWr && (regIdx == IDX_W'(IDX_EN));
    strb.flagRd  = busRd && (regIdx == IDX_W'(IDX_FLAG));
    strb.enRd    = busRd && (regIdx == IDX_W'(IDX_EN));
    strb.shiftRd = busRd && (regIdx == IDX_W'(IDX_SHIFT));
  end
endmodule

// File: rtl/irq_flag_pair_regs.sv
module irq_flag_pair_regs
  import irq_flag_pair_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SHIFT_BIT = 2,
  parameter int T1_BIT    = 6,
  parameter int T2_BIT    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [SRC_N-1:0]  setPulse,
  input  logic [SRC_N-1:0]  clrAccess,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  localparam logic [SRC_N-1:0] IRQ_MASK =
    SRC_N'((1 << SHIFT_BIT) | (1 << T1_BIT));
  localparam logic [SRC_N-1:0] T2_ONLY = SRC_N'(1 << T2_BIT);

  logic [SRC_N-1:0] flagQ;
  logic [SRC_N-1:0] enQ;
  logic [SRC_N-1:0] clrVec;
  logic             anyPending;

  // Gather every clear source that can hit a flag this cycle.
  always_comb begin
    clrVec = clrAccess;
    if (strb.flagWr) clrVec = clrVec | strb.bits;
    if (strb.shiftRd) clrVec[SHIFT_BIT] = 1'b1;
  end

  // One flag cell per source; a set in the same cycle beats any clear.
  for (genvar k = 0; k < SRC_N; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)             flagQ[k] <= 1'b0;
      else if (setPulse[k])  flagQ[k] <= 1'b1;
      else if (clrVec[k])    flagQ[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ <= '0;
    end else if (strb.enWr) begin
      if (strb.enSet) enQ <= enQ | strb.bits;
      else            enQ <= enQ & ~strb.bits;
    end
  end

  assign anyPending = |(flagQ & enQ);
  assign irqOut     = |(flagQ & enQ & IRQ_MASK);

  always_comb begin
    rdData = '0;
    if (strb.flagRd)    rdData = {anyPending, flagQ};
    else if (strb.enRd) rdData = {1'b1, enQ};
  end

  a_r2_set_takes: assert property (@(posedge clk) disable iff (!rstN)
    (setPulse != '0) |=> ((flagQ & $past(setPulse)) == $past(setPulse)));

  a_r3_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.flagWr |=> ((flagQ & $past(strb.bits & ~setPulse)) == '0));

  a_r4_enable_or: assert property (@(posedge clk) disable iff (!rstN)
    (strb.enWr && strb.enSet) |=> ((enQ & $past(strb.bits)) == $past(strb.bits)));

  a_r5_enable_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.enWr && !strb.enSet) |=> ((enQ & $past(strb.bits)) == '0));

  a_r12_enable_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.enWr |=> $stable(enQ));

  a_r6_summary_bit: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flagRd && irqOut) |-> rdData[DATA_W-1]);

  a_r7_enable_top: assert property (@(posedge clk) disable iff (!rstN)
    strb.enRd |-> rdData[DATA_W-1]);

  a_r8_t2_silent: assert property (@(posedge clk) disable iff (!rstN)
    ((flagQ & enQ) == T2_ONLY) |-> !irqOut);

  a_r9_shift_read: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftRd && !setPulse[SHIFT_BIT]) |=> !flagQ[SHIFT_BIT]);

  a_r10_strobe_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrAccess != '0) |=> ((flagQ & $past(clrAccess & ~setPulse)) == '0));
endmodule

// File: rtl/irq_flag_pair.sv
module irq_flag_pair
  import irq_flag_pair_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int IDX_LO    = 9,
  parameter int DATA_W    = 8,
  parameter int SHIFT_BIT = 2,
  parameter int T1_BIT    = 6,
  parameter int T2_BIT    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [6:0]        setPulse,
  input  logic [6:0]        clrAccess,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  ctrlStrobes_t strb;

  irq_flag_pair_decode #(
    .ADDR_W(ADDR_W), .IDX_LO(IDX_LO), .IDX_W(ADDR_W - IDX_LO), .DATA_W(DATA_W),
    .IDX_FLAG(13), .IDX_EN(14), .IDX_SHIFT(10)
  ) u_decode (
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .wrData(wrData), .strb(strb)
  );

  irq_flag_pair_regs #(
    .DATA_W(DATA_W), .SHIFT_BIT(SHIFT_BIT), .T1_BIT(T1_BIT), .T2_BIT(T2_BIT)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .setPulse(setPulse),
    .clrAccess(clrAccess), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/irq_flag_pair_test.sv
module irq_flag_pair_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [12:0] busAddr = '0;
  logic [7:0]  wrData = '0;
  logic [6:0]  setPulse = '0;
  logic [6:0]  clrAccess = '0;
  logic [7:0]  rdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mFlags = 0;
  int mEn = 0;

  always #2 clk = ~clk;

  irq_flag_pair uut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .wrData(wrData), .setPulse(setPulse), .clrAccess(clrAccess),
    .rdData(rdData), .irqOut(irqOut)
  );

  function automatic int expRd(bit rd, int idx);
    if (!rd) return 0;
    if (idx == 13) return mFlags | (((mFlags & mEn) != 0) ? 'h80 : 0);
    if (idx == 14) return mEn | 'h80;
    return 0;
  endfunction

  task automatic step(input bit wr, input bit rd, input int idx, input int d,
                      input int s, input int c, input int lo, input string tag);
    int er;
    bit ei;
    int clr;
    busWr = wr; busRd = rd; busAddr = 13'((idx << 9) | lo);
    wrData = 8'(d); setPulse = 7'(s); clrAccess = 7'(c);
    #1;
    er = expRd(rd, idx);
    ei = ((mFlags & mEn & 'h44) != 0);
    checks += 2;
    if (rdData !== 8'(er)) begin
      errors++;
      $display("FAIL %s rdData actual %02h expected %02h", tag, rdData, er);
    end
    if (irqOut !== ei) begin
      errors++;
      $display("FAIL %s irqOut actual %0b expected %0b", tag, irqOut, ei);
    end
    @(posedge clk);
    clr = c;
    if (wr && idx == 13) clr |= d & 'h7f;
    if (rd && idx == 10) clr |= 'h04;
    mFlags = ((mFlags & ~clr) | s) & 'h7f;
    if (wr && idx == 14) begin
      if (d & 'h80) mEn = (mEn | d) & 'h7f;
      else          mEn = mEn & ~d & 'h7f;
    end
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    step(0, 1, 13, 0, 0, 0, 0, "R1 flags after reset");
    step(0, 1, 14, 0, 0, 0, 0, "R1 enables after reset");
    // R2: set pulses
    step(0, 0, 0, 0, 'h24, 0, 0, "R2 set shift and t2");
    step(0, 1, 13, 0, 0, 0, 0, "R2 read flags");
    // R8: timer 2 enabled only -> no request; R6 summary set
    step(1, 0, 14, 'hA0, 0, 0, 0, "R4 enable t2");
    step(0, 1, 13, 0, 0, 0, 0, "R6 R8 t2 pending only");
    // R4 enable shift -> request
    step(1, 0, 14, 'h84, 0, 0, 'h1FF, "R4 enable shift, low addr bits R12");
    step(0, 1, 14, 0, 0, 0, 0, "R7 read enables");
    step(0, 1, 13, 0, 0, 0, 0, "R8 shift request");
    // R9: shift data read clears shift flag only
    step(0, 1, 10, 0, 0, 0, 0, "R9 shift data read");
    step(0, 1, 13, 0, 0, 0, 0, "R9 after shift read");
    // R3: write clears ones only, bit 7 ignored
    step(0, 0, 0, 0, 'h7f, 0, 0, "R2 set all");
    step(1, 0, 13, 'hA1, 0, 0, 0, "R3 clear 0x21");
    step(0, 1, 13, 0, 0, 0, 0, "R3 after clear");
    // R5: enable clear
    step(1, 0, 14, 'h04, 0, 0, 0, "R5 clear shift enable");
    step(0, 1, 14, 0, 0, 0, 0, "R5 enables");
    step(1, 0, 14, 'hC0, 0, 0, 0, "R4 enable t1");
    step(0, 1, 13, 0, 0, 0, 0, "R8 t1 request");
    // R10: clear strobe
    step(0, 0, 0, 0, 0, 'h40, 0, "R10 strobe t1");
    step(0, 1, 13, 0, 0, 0, 0, "R10 after strobe");
    // R11: set beats clear (write, read, strobe)
    step(1, 0, 13, 'h7f, 'h40, 0, 0, "R11 set vs write");
    step(0, 1, 10, 0, 'h04, 'h40, 0, "R11 set shift vs read, t1 strobe");
    step(0, 0, 0, 0, 'h40, 'h40, 0, "R11 set vs strobe");
    step(0, 1, 13, 0, 0, 0, 0, "R11 flags kept");
    // R12: other indices ignored, read data zero otherwise
    step(1, 0, 12, 'hFF, 0, 0, 0, "R12 write other idx");
    step(1, 0, 15, 'h00, 0, 0, 0, "R12 write idx 15");
    step(0, 1, 3, 0, 0, 0, 0, "R12 read other idx");
    step(0, 1, 13, 0, 0, 0, 0, "R12 flags unchanged");
    step(0, 1, 14, 0, 0, 0, 0, "R12 enables unchanged");
    idle("R12 idle read data");
    // R1: reset again from a busy state
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    rstN = 1'b1;
    mFlags = 0; mEn = 0;
    step(0, 1, 13, 0, 0, 0, 0, "R1 flags after second reset");
    step(0, 1, 14, 0, 0, 0, 0, "R1 enables after second reset");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule